// File: doc/BRIEF.md
# Wavefront SIMD Issue Cluster

The block is a vector compute cluster of four SIMD engines. Each engine is permanently tied to one resident wavefront of 64 work-items and has 16 integer lanes. One vector instruction is therefore carried out in four consecutive passes of 16 elements. A round-robin issue pointer gives each engine an issue slot once every four cycles. An engine that finished its previous instruction on time takes a new one every four cycles, and the four engines start on staggered cycles. Throughput comes only from running several wavefronts side by side. Two instructions of the same wavefront never overlap.

Instructions enter through one valid/ready push channel that carries a wavefront index. Each wavefront has its own small queue. `push_ready` reflects the queue addressed by `push_wave` in the same cycle. A beat is taken only when `push_valid` and `push_ready` are both high, and a refused beat changes nothing. Instructions can be flagged as double precision. Such an instruction holds its engine for longer, according to a rate code. Each engine owns a banked vector register file: one bank per pass, each bank 16 lanes wide. Side ports let the host load and inspect single register elements while the cluster is idle. A per-wavefront `done` pulse reports that the queue has drained.

Top module: `wave_cluster`

## Requirements
- R1: Pass k (k = 0..3) of an instruction reads and writes only elements 16k..16k+15 of its vector registers, and the passes run in ascending order.
- R2: A single-precision instruction holds its engine for exactly 4 cycles. The next instruction of the same wavefront starts only after the current one has retired.
- R3: A double-precision instruction (`push_dp`=1) holds its engine for 8 cycles when `dp_rate`=0, 16 cycles when `dp_rate`=1, and 64 cycles when `dp_rate` is 2 or 3. Its passes are spread evenly over that time. `dp_rate` is sampled when the instruction starts.
- R4: The issue pointer is 0 in the first cycle after reset and advances by one every cycle, wrapping after 3. Engine w can start only in a cycle where the pointer equals w, so at most one instruction starts per cycle.
- R5: Instructions pushed with `push_wave`=w change only the registers of engine w.
- R6: When bit e of the 64-bit mask slice `exec_mask[64w+63:64w]` is 0, element e of the destination register of wavefront w is not written. The mask is sampled when the instruction starts.
- R7: Each wavefront queue holds 4 instructions. `push_ready` is low while the addressed queue is full, and a beat with `push_ready` low is ignored.
- R8: `done[w]` is high for exactly one cycle after the clock edge at which an instruction of wavefront w retires while its queue is empty at that edge.
- R9: While reset is asserted and after it is released, `done` is 0 and `push_ready` is 1.
- R10: Opcode encoding on `push_op`: 0 writes src0+src1, 1 writes src0−src1, 2 writes the low 32 bits of src0×src1, 3 copies src0. All arithmetic is modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_rate | input | 2 | Double-precision rate code |
| push_valid | input | 1 | Instruction beat valid |
| push_wave | input | 2 | Target wavefront of the beat |
| push_ready | output | 1 | Addressed queue can accept the beat |
| push_op | input | 2 | Opcode |
| push_dst | input | 3 | Destination vector register |
| push_src0 | input | 3 | First source vector register |
| push_src1 | input | 3 | Second source vector register |
| push_dp | input | 1 | Double-precision flag |
| exec_mask | input | 256 | Four 64-bit execution masks, wavefront w in bits 64w+63..64w |
| rf_load_en | input | 1 | Write one register element from the host side |
| rf_load_wave | input | 2 | Engine for the host write |
| rf_load_reg | input | 3 | Register for the host write |
| rf_load_elem | input | 6 | Element for the host write |
| rf_load_data | input | 32 | Host write data |
| rf_peek_wave | input | 2 | Engine for the inspection read |
| rf_peek_reg | input | 3 | Register for the inspection read |
| rf_peek_elem | input | 6 | Element for the inspection read |
| rf_peek_data | output | 32 | Inspection read data, combinational |
| done | output | 4 | Per-wavefront drained pulse |

## Verification
The bench builds the cluster with its defaults: four wavefronts of 64 elements on 16 lanes, eight 32-bit registers per engine and a queue depth of four. At this size the whole register state (2048 elements) can be loaded at random and read back in full after every phase. Pushing into a single wavefront fills its queue within a few cycles, so back-pressure is exercised. All four rate codes, including the 64-cycle one, fit in short instruction streams. The reference model follows queue occupancy, the issue pointer and pass timing cycle by cycle. It compares `done` and `push_ready` on every clock and the register contents at the end of each phase.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_MOV = 2'd3
  } vop_e;

  // width of the per-pass sub-cycle counter (largest stretch is 16)
  localparam int SUBW = 4;

  // cycles spent on each pass of a double-precision instruction
  function automatic logic [4:0] dp_subcycles(input logic [1:0] rate);
    case (rate)
      2'd0:    return 5'd2;
      2'd1:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/wc_instr_fifo.sv
module wc_instr_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);

endmodule

// File: rtl/wc_vrf.sv
module wc_vrf #(
  parameter int LANES  = 16,
  parameter int PASSES = 4,
  parameter int VREGS  = 8,
  parameter int DW     = 32
) (
  input  logic                             clk,
  input  logic [$clog2(PASSES)-1:0]        bank_sel,
  input  logic [$clog2(VREGS)-1:0]         rd_a_reg,
  input  logic [$clog2(VREGS)-1:0]         rd_b_reg,
  output logic [LANES*DW-1:0]              rd_a,
  output logic [LANES*DW-1:0]              rd_b,
  input  logic                             wr_en,
  input  logic [$clog2(VREGS)-1:0]         wr_reg,
  input  logic [LANES-1:0]                 wr_lmask,
  input  logic [LANES*DW-1:0]              wr_data,
  input  logic                             ld_en,
  input  logic [$clog2(VREGS)-1:0]         ld_reg,
  input  logic [$clog2(LANES*PASSES)-1:0]  ld_elem,
  input  logic [DW-1:0]                    ld_data,
  input  logic [$clog2(VREGS)-1:0]         pk_reg,
  input  logic [$clog2(LANES*PASSES)-1:0]  pk_elem,
  output logic [DW-1:0]                    pk_data
);
  localparam int LAW = $clog2(LANES);
  localparam int PAW = $clog2(PASSES);
  localparam int EAW = $clog2(LANES * PASSES);

  logic [LAW-1:0] ld_lane, pk_lane;
  logic [PAW-1:0] ld_bank, pk_bank;
  assign ld_lane = ld_elem[LAW-1:0];
  assign ld_bank = ld_elem[EAW-1:LAW];
  assign pk_lane = pk_elem[LAW-1:0];
  assign pk_bank = pk_elem[EAW-1:LAW];

  logic [LANES*DW-1:0] bank_a  [PASSES];
  logic [LANES*DW-1:0] bank_b  [PASSES];
  logic [DW-1:0]       bank_pk [PASSES];

  // one bank per pass, each holding 16 lanes of every register
  for (genvar b = 0; b < PASSES; b++) begin : g_bank
    logic [DW-1:0]       mem [VREGS][LANES];
    logic [LANES*DW-1:0] ra, rb;

    always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && bank_sel == PAW'(b) && wr_lmask[l])
          mem[wr_reg][l] <= wr_data[l*DW +: DW];
        else if (ld_en && ld_bank == PAW'(b) && ld_lane == LAW'(l))
          mem[ld_reg][l] <= ld_data;
      end
    end

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        ra[l*DW +: DW] = mem[rd_a_reg][l];
        rb[l*DW +: DW] = mem[rd_b_reg][l];
      end
    end

    assign bank_a[b]  = ra;
    assign bank_b[b]  = rb;
    assign bank_pk[b] = mem[pk_reg][pk_lane];
  end

  assign rd_a    = bank_a[bank_sel];
  assign rd_b    = bank_b[bank_sel];
  assign pk_data = bank_pk[pk_bank];

endmodule

// File: rtl/wc_simd.sv
module wc_simd
  import wc_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int PASSES = 4,
  parameter int VREGS  = 8,
  parameter int DW     = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  vop_e                             in_op,
  input  logic [$clog2(VREGS)-1:0]         in_dst,
  input  logic [$clog2(VREGS)-1:0]         in_s0,
  input  logic [$clog2(VREGS)-1:0]         in_s1,
  input  logic                             in_dp,
  input  logic [LANES*PASSES-1:0]          in_mask,
  input  logic [1:0]                       dp_rate,
  output logic                             busy,
  output logic                             retire,
  input  logic                             ld_en,
  input  logic [$clog2(VREGS)-1:0]         ld_reg,
  input  logic [$clog2(LANES*PASSES)-1:0]  ld_elem,
  input  logic [DW-1:0]                    ld_data,
  input  logic [$clog2(VREGS)-1:0]         pk_reg,
  input  logic [$clog2(LANES*PASSES)-1:0]  pk_elem,
  output logic [DW-1:0]                    pk_data
);
  localparam int WAVE = LANES * PASSES;
  localparam int RAW  = $clog2(VREGS);
  localparam int PAW  = $clog2(PASSES);

  // held instruction
  logic            busy_q, dp_q;
  logic [PAW-1:0]  pass_q;
  logic [SUBW-1:0] sub_q, qlim_q, qlim_n;
  vop_e            op_q;
  logic [RAW-1:0]  dst_q, s0_q, s1_q;
  logic [WAVE-1:0] mask_q;

  // fields of the pass executed this cycle
  vop_e            cur_op;
  logic [RAW-1:0]  cur_dst, cur_s0, cur_s1;
  logic [WAVE-1:0] cur_mask;
  logic [PAW-1:0]  pass_idx;
  logic            exec;
  logic [LANES-1:0]    lane_en;
  logic [LANES*DW-1:0] rd_a, rd_b, res;

  assign busy    = busy_q;
  assign qlim_n  = in_dp ? SUBW'(dp_subcycles(dp_rate) - 5'd1) : '0;
  assign retire  = busy_q && (pass_q == PAW'(PASSES - 1)) && (sub_q == qlim_q);
  assign exec    = start || (busy_q && sub_q == '0);
  assign pass_idx = start ? '0 : pass_q;
  assign cur_op   = start ? in_op   : op_q;
  assign cur_dst  = start ? in_dst  : dst_q;
  assign cur_s0   = start ? in_s0   : s0_q;
  assign cur_s1   = start ? in_s1   : s1_q;
  assign cur_mask = start ? in_mask : mask_q;
  assign lane_en  = cur_mask[int'(pass_idx)*LANES +: LANES];

  always_ff @(posedge clk) begin
    if (start) begin
      op_q   <= in_op;
      dst_q  <= in_dst;
      s0_q   <= in_s0;
      s1_q   <= in_s1;
      dp_q   <= in_dp;
      mask_q <= in_mask;
      qlim_q <= qlim_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pass_q <= '0;
      sub_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      if (qlim_n == '0) begin
        pass_q <= PAW'(1);
        sub_q  <= '0;
      end else begin
        pass_q <= '0;
        sub_q  <= SUBW'(1);
      end
    end else if (busy_q) begin
      if (retire) begin
        busy_q <= 1'b0;
        pass_q <= '0;
        sub_q  <= '0;
      end else if (sub_q == qlim_q) begin
        sub_q  <= '0;
        pass_q <= pass_q + 1'b1;
      end else begin
        sub_q  <= sub_q + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] a, b, r;
    assign a = rd_a[l*DW +: DW];
    assign b = rd_b[l*DW +: DW];
    always_comb begin
      case (cur_op)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        OP_MUL:  r = a * b;
        default: r = a;
      endcase
    end
    assign res[l*DW +: DW] = r;
  end

  wc_vrf #(.LANES(LANES), .PASSES(PASSES), .VREGS(VREGS), .DW(DW)) u_vrf (
    .clk      (clk),
    .bank_sel (pass_idx),
    .rd_a_reg (cur_s0),
    .rd_b_reg (cur_s1),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .wr_en    (exec),
    .wr_reg   (cur_dst),
    .wr_lmask (lane_en),
    .wr_data  (res),
    .ld_en    (ld_en),
    .ld_reg   (ld_reg),
    .ld_elem  (ld_elem),
    .ld_data  (ld_data),
    .pk_reg   (pk_reg),
    .pk_elem  (pk_elem),
    .pk_data  (pk_data)
  );

  // checker state: cycles since start, and the rate seen at start
  logic [6:0] occ_q;
  logic [1:0] rate_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q  <= '0;
      rate_q <= '0;
    end else if (start) begin
      occ_q  <= 7'd1;
      rate_q <= dp_rate;
    end else if (busy_q) begin
      occ_q  <= occ_q + 7'd1;
    end
  end

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  assert_sp_four_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !dp_q) |-> $past(start, 3));

  assert_dp_occupancy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && dp_q) |-> (occ_q == 7'({dp_subcycles(rate_q), 2'b00}) - 7'd1));

endmodule

// File: rtl/wave_cluster.sv
module wave_cluster
  import wc_pkg::*;
#(
  parameter int NUM_WAVES  = 4,
  parameter int WAVE_W     = 64,
  parameter int LANES      = 16,
  parameter int VREGS      = 8,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     dp_rate,
  input  logic                           push_valid,
  input  logic [$clog2(NUM_WAVES)-1:0]   push_wave,
  output logic                           push_ready,
  input  logic [1:0]                     push_op,
  input  logic [$clog2(VREGS)-1:0]       push_dst,
  input  logic [$clog2(VREGS)-1:0]       push_src0,
  input  logic [$clog2(VREGS)-1:0]       push_src1,
  input  logic                           push_dp,
  input  logic [NUM_WAVES*WAVE_W-1:0]    exec_mask,
  input  logic                           rf_load_en,
  input  logic [$clog2(NUM_WAVES)-1:0]   rf_load_wave,
  input  logic [$clog2(VREGS)-1:0]       rf_load_reg,
  input  logic [$clog2(WAVE_W)-1:0]      rf_load_elem,
  input  logic [DW-1:0]                  rf_load_data,
  input  logic [$clog2(NUM_WAVES)-1:0]   rf_peek_wave,
  input  logic [$clog2(VREGS)-1:0]       rf_peek_reg,
  input  logic [$clog2(WAVE_W)-1:0]      rf_peek_elem,
  output logic [DW-1:0]                  rf_peek_data,
  output logic [NUM_WAVES-1:0]           done
);
  localparam int PASSES = WAVE_W / LANES;
  localparam int WAW    = $clog2(NUM_WAVES);
  localparam int RAW    = $clog2(VREGS);
  localparam int IW     = 2 + 3 * RAW + 1;

  logic [WAW-1:0]       rr_q;
  logic [NUM_WAVES-1:0] full, empty, start, busy, retire;
  logic [IW-1:0]        head  [NUM_WAVES];
  logic [DW-1:0]        peek  [NUM_WAVES];
  logic [IW-1:0]        push_word;

  assign push_word  = {push_op, push_dst, push_src0, push_src1, push_dp};
  assign push_ready = !full[push_wave];
  assign rf_peek_data = peek[rf_peek_wave];

  // issue pointer: one engine slot per cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                           rr_q <= '0;
    else if (rr_q == WAW'(NUM_WAVES - 1)) rr_q <= '0;
    else                                  rr_q <= rr_q + 1'b1;
  end

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    logic push_w;
    assign push_w   = push_valid && push_ready && (push_wave == WAW'(w));
    assign start[w] = (rr_q == WAW'(w)) && !busy[w] && !empty[w];

    wc_instr_fifo #(.W(IW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_w),
      .din   (push_word),
      .pop   (start[w]),
      .dout  (head[w]),
      .full  (full[w]),
      .empty (empty[w])
    );

    wc_simd #(.LANES(LANES), .PASSES(PASSES), .VREGS(VREGS), .DW(DW)) u_simd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start[w]),
      .in_op   (vop_e'(head[w][IW-1 -: 2])),
      .in_dst  (head[w][IW-3 -: RAW]),
      .in_s0   (head[w][IW-3-RAW -: RAW]),
      .in_s1   (head[w][RAW:1]),
      .in_dp   (head[w][0]),
      .in_mask (exec_mask[w*WAVE_W +: WAVE_W]),
      .dp_rate (dp_rate),
      .busy    (busy[w]),
      .retire  (retire[w]),
      .ld_en   (rf_load_en && rf_load_wave == WAW'(w)),
      .ld_reg  (rf_load_reg),
      .ld_elem (rf_load_elem),
      .ld_data (rf_load_data),
      .pk_reg  (rf_peek_reg),
      .pk_elem (rf_peek_elem),
      .pk_data (peek[w])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) done[w] <= 1'b0;
      else        done[w] <= retire[w] && empty[w];
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done[w] |=> !done[w]);
  end

  assert_one_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));

endmodule

// File: tb/wave_cluster_tb.sv
module wave_cluster_tb;
  localparam int NW = 4, WW = 64, NR = 8, DW = 32, FD = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [1:0]    dp_rate;
  logic          push_valid, push_ready, push_dp;
  logic [1:0]    push_wave, push_op;
  logic [2:0]    push_dst, push_src0, push_src1;
  logic [NW*WW-1:0] exec_mask;
  logic          rf_load_en;
  logic [1:0]    rf_load_wave, rf_peek_wave;
  logic [2:0]    rf_load_reg, rf_peek_reg;
  logic [5:0]    rf_load_elem, rf_peek_elem;
  logic [DW-1:0] rf_load_data, rf_peek_data;
  logic [NW-1:0] done;

  wave_cluster u_dut (
    .clk(clk), .rst_n(rst_n), .dp_rate(dp_rate),
    .push_valid(push_valid), .push_wave(push_wave), .push_ready(push_ready),
    .push_op(push_op), .push_dst(push_dst), .push_src0(push_src0),
    .push_src1(push_src1), .push_dp(push_dp), .exec_mask(exec_mask),
    .rf_load_en(rf_load_en), .rf_load_wave(rf_load_wave), .rf_load_reg(rf_load_reg),
    .rf_load_elem(rf_load_elem), .rf_load_data(rf_load_data),
    .rf_peek_wave(rf_peek_wave), .rf_peek_reg(rf_peek_reg),
    .rf_peek_elem(rf_peek_elem), .rf_peek_data(rf_peek_data), .done(done)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  string done_tag = "R8";

  // behavioural reference state
  int unsigned mreg [NW][NR][WW];
  bit [11:0]   mq   [NW][$];
  bit          mbusy[NW];
  int          mel  [NW];
  int          mlen [NW];
  bit [11:0]   mcur [NW];
  logic [63:0] mmask[NW];
  bit          mdone[NW];
  int          mrr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void do_pass(input int w, input int k);
    for (int l = 0; l < 16; l++) begin
      int e;
      int unsigned a, b, r;
      e = 16 * k + l;
      a = mreg[w][mcur[w][6:4]][e];
      b = mreg[w][mcur[w][3:1]][e];
      case (mcur[w][11:10])
        2'd0: r = a + b;
        2'd1: r = a - b;
        2'd2: r = a * b;
        default: r = a;
      endcase
      if (mmask[w][e]) mreg[w][mcur[w][9:7]][e] = r;
    end
  endfunction

  function automatic int sub_of(input logic [1:0] rate);
    return (rate == 2'd0) ? 2 : (rate == 2'd1) ? 4 : 16;
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      mrr = 0;
      for (int w = 0; w < NW; w++) begin
        mbusy[w] = 0; mdone[w] = 0; mq[w].delete();
      end
    end else begin
      acc = push_valid && (mq[push_wave].size() < FD);
      if (rf_load_en) mreg[rf_load_wave][rf_load_reg][rf_load_elem] = rf_load_data;
      for (int w = 0; w < NW; w++) begin
        mdone[w] = 0;
        if (mbusy[w]) begin
          int q;
          q = mlen[w] / 4;
          if (mel[w] % q == 0) do_pass(w, mel[w] / q);
          if (mel[w] == mlen[w] - 1) begin
            mbusy[w] = 0;
            mdone[w] = (mq[w].size() == 0);
          end else mel[w]++;
        end else if (mrr == w && mq[w].size() > 0) begin
          mcur[w]  = mq[w].pop_front();
          mmask[w] = exec_mask[w*WW +: WW];
          mlen[w]  = mcur[w][0] ? 4 * sub_of(dp_rate) : 4;
          mbusy[w] = 1;
          do_pass(w, 0);
          mel[w] = 1;
        end
      end
      if (acc) mq[push_wave].push_back({push_op, push_dst, push_src0, push_src1, push_dp});
      mrr = (mrr + 1) % NW;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int w = 0; w < NW; w++)
        chk(done[w] == mdone[w], done_tag, $sformatf("done[%0d]", w), done[w], mdone[w]);
      chk(push_ready == (mq[push_wave].size() < FD), "R7", "push_ready",
          push_ready, mq[push_wave].size() < FD);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  function automatic bit model_idle();
    for (int w = 0; w < NW; w++)
      if (mbusy[w] || mq[w].size() != 0) return 0;
    return 1;
  endfunction

  task automatic run_phase(input int per_wave, input int dp_pct, input int only_wave,
                           input string dtag, input string rtag);
    int left[NW];
    int w;
    bit acc;
    for (int i = 0; i < NW; i++) left[i] = (only_wave < 0 || only_wave == i) ? per_wave : 0;
    done_tag = dtag;
    w = 0;
    while (left[0] + left[1] + left[2] + left[3] > 0) begin
      while (left[w] == 0) w = (w + 1) % NW;
      push_valid = 1;
      push_wave  = 2'(w);
      push_op    = 2'($urandom);
      push_dst   = 3'($urandom);
      push_src0  = 3'($urandom);
      push_src1  = 3'($urandom);
      push_dp    = ($urandom % 100) < dp_pct;
      acc = mq[w].size() < FD;
      tick();
      if (acc) left[w]--;
      w = (w + 1) % NW;
    end
    push_valid = 0;
    while (!model_idle()) tick();
    repeat (3) tick();
    for (int v = 0; v < NW; v++)
      for (int r = 0; r < NR; r++)
        for (int e = 0; e < WW; e++) begin
          rf_peek_wave = 2'(v); rf_peek_reg = 3'(r); rf_peek_elem = 6'(e);
          #1;
          chk(rf_peek_data == mreg[v][r][e], rtag,
              $sformatf("reg w%0d v%0d e%0d", v, r, e), rf_peek_data, mreg[v][r][e]);
        end
  endtask

  initial begin
    rst_n = 0; dp_rate = 0; push_valid = 0; push_wave = 0; push_op = 0;
    push_dst = 0; push_src0 = 0; push_src1 = 0; push_dp = 0;
    exec_mask = '1; rf_load_en = 0; rf_load_wave = 0; rf_load_reg = 0;
    rf_load_elem = 0; rf_load_data = 0; rf_peek_wave = 0; rf_peek_reg = 0; rf_peek_elem = 0;
    repeat (3) tick();
    chk(done == '0, "R9", "done in reset", done, 0);
    chk(push_ready == 1'b1, "R9", "push_ready in reset", push_ready, 1);
    rst_n = 1;
    tick();
    chk(done == '0, "R9", "done after reset", done, 0);
    chk(push_ready == 1'b1, "R9", "push_ready after reset", push_ready, 1);

    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++)
        for (int e = 0; e < WW; e++) begin
          rf_load_en = 1; rf_load_wave = 2'(w); rf_load_reg = 3'(r);
          rf_load_elem = 6'(e); rf_load_data = $urandom;
          tick();
        end
    rf_load_en = 0;
    tick();

    // all opcodes, full masks, single precision
    run_phase(12, 0, -1, "R2", "R10");
    // random masks
    for (int i = 0; i < NW * 2; i++) exec_mask[i*32 +: 32] = $urandom;
    run_phase(12, 0, -1, "R8", "R6");
    // one wavefront only, queue fills, rate code 0
    dp_rate = 2'd0;
    run_phase(16, 50, 1, "R4", "R5");
    // longer double-precision rates
    exec_mask = '1;
    dp_rate = 2'd1;
    run_phase(6, 50, -1, "R3", "R1");
    dp_rate = 2'd2;
    run_phase(4, 50, -1, "R3", "R1");
    dp_rate = 2'd3;
    run_phase(3, 70, -1, "R3", "R1");

    finish_run();
  end

endmodule